// File: doc/BRIEF.md
# Two-Tier Shared Spare Repair Datapath

This block sits between a stack of two memory tiers and the logic that uses them, after the tiers have been bonded. Each tier has a small remap table. A table entry redirects one faulty row or one faulty column of its own tier to a spare row or spare column. That spare may sit in the same tier or be borrowed from the other tier. On every access, all entries of the accessed tier's table are compared at once. The block then picks whether the read data comes from the main array of the accessed tier or from the chosen spare of the owning tier.

Each tier also carries its own self-repair controller. After bonding, only one controller is master. The master drives the arrays in self-repair mode and is the only source allowed to program the remap tables. The other controller stays as a standby slave. When the master reports itself faulty and the slave does not, the roles are exchanged once no test is running. A mode wrapper routes the array address either from the functional port (normal mode) or from the master controller's port (self-repair mode).

Top module: `dual_tier_repair`

## Requirements
- R1: After reset, controller 0 is master (`master_id`=0), `role_chg` is 0, and every remap entry is invalid, so every read returns the main data of the accessed tier.
- R2: When no valid entry of the accessed tier matches, `rd_data` is the main data of `mem_tier` and `rd_src` is 0 (main). An entry whose valid bit is cleared never matches.
- R3: A valid column entry (type bit 1) whose address equals `mem_col` makes `rd_data` the spare-column word at (owner tier, spare index), with `rd_src`=2.
- R4: A valid row entry (type bit 0) whose address equals `mem_row` makes `rd_data` the spare-row word at (owner tier, spare index), with `rd_src`=1. If a row entry and a column entry both match, the row entry decides.
- R5: The owner-tier bit of an entry may name the other tier, and the spare word is then taken from that tier. `rd_spare_tier` and `rd_spare_idx` report the chosen spare.
- R6: A remap write is applied only while `test_mode` is 1. A write presented while `test_mode` is 0 leaves the lookup results unchanged.
- R7: A lookup uses only the table of the accessed tier. An entry stored for one tier has no effect on accesses to the other tier.
- R8: With `test_mode`=0, `mem_en`/`mem_tier`/`mem_row`/`mem_col` follow the functional port. With `test_mode`=1, they follow the port of the controller named by `master_id` (index 0 = low slice).
- R9: When the master's fault flag is 1, the slave's is 0, and `test_busy` is 0 at a clock edge, `master_id` toggles at that edge and `role_chg` is 1 for exactly the following cycle.
- R10: While `test_busy` is 1, no role exchange happens. A pending exchange takes effect at the first edge where `test_busy` is 0.
- R11: No exchange happens when both controllers report a fault, or when only the slave does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| test_mode | input | 1 | 1 = self-repair mode, 0 = normal mode |
| fn_en | input | 1 | Functional access enable |
| fn_tier | input | 1 | Functional access tier |
| fn_row | input | ROW_W | Functional row address |
| fn_col | input | COL_W | Functional column address |
| ctl_en | input | 2 | Access enable from each tier's controller |
| ctl_tier | input | 2 | Target tier from each controller |
| ctl_row | input | 2*ROW_W | Row address from each controller (controller 0 low) |
| ctl_col | input | 2*COL_W | Column address from each controller |
| ctl_fault | input | 2 | Fault flag of each controller |
| test_busy | input | 1 | Master test in progress |
| wr_en | input | 1 | Remap entry write strobe |
| wr_tier | input | 1 | Tier whose table is written |
| wr_slot | input | SLOT_W | Entry slot |
| wr_valid | input | 1 | Entry valid bit |
| wr_is_col | input | 1 | Entry type: 0 row, 1 column |
| wr_addr | input | AW | Faulty row or column address |
| wr_owner | input | 1 | Tier holding the spare |
| wr_sidx | input | SIDX_W | Spare index in the owner tier |
| main_rd | input | 2*DATA_W | Main array read data per tier |
| spr_row_rd | input | 2*N_SPR*DATA_W | Spare row read data, word (t*N_SPR+i) |
| spr_col_rd | input | 2*N_SPR*DATA_W | Spare column read data, word (t*N_SPR+i) |
| mem_en | output | 1 | Array access enable after the wrapper |
| mem_tier | output | 1 | Accessed tier |
| mem_row | output | ROW_W | Array row address |
| mem_col | output | COL_W | Array column address |
| rd_data | output | DATA_W | Selected read data |
| rd_src | output | 2 | 0 main, 1 spare row, 2 spare column |
| rd_spare_tier | output | 1 | Tier of the selected spare |
| rd_spare_idx | output | SIDX_W | Index of the selected spare |
| master_id | output | 1 | Current master controller |
| role_chg | output | 1 | One-cycle pulse on a role exchange |

## Verification
A corrupted remap entry shows up on `rd_data` and `rd_src` in the same cycle as the first access to its address. Stale or ignored writes show up on the first read after the write, because the lookup path is combinational. A wrong master register changes `mem_row` in self-repair mode at once. If the exchange fires when it should not, `role_chg` rises one cycle after the edge that decided it. For this reason, every role check samples just before the next edge.

// File: rtl/tsr_pkg.sv
// Shared types and helpers for the two-tier spare repair datapath.
package tsr_pkg;

    // Read data source reported on rd_src
    typedef enum logic [1:0] {
        SRC_MAIN = 2'd0,
        SRC_ROW  = 2'd1,
        SRC_COL  = 2'd2
    } src_e;

    // Larger of two widths
    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/tsr_remap_table.sv
// Remap table of one tier. Holds N_ENT entries of
// {valid, is_col, faulty address, owner tier, spare index}.
// A write is taken only when wr_ok is set and wr_tier names this tier.
// Lookup compares all entries in parallel; the lowest matching slot wins
// within each type.
module tsr_remap_table #(
    parameter int TIER   = 0,
    parameter int N_ENT  = 4,
    parameter int SLOT_W = 2,
    parameter int AW     = 6,
    parameter int ROW_W  = 6,
    parameter int COL_W  = 4,
    parameter int SIDX_W = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ok,
    input  logic              wr_tier,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic              wr_valid,
    input  logic              wr_is_col,
    input  logic [AW-1:0]     wr_addr,
    input  logic              wr_owner,
    input  logic [SIDX_W-1:0] wr_sidx,
    input  logic [ROW_W-1:0]  lk_row,
    input  logic [COL_W-1:0]  lk_col,
    output logic              row_hit,
    output logic              row_owner,
    output logic [SIDX_W-1:0] row_idx,
    output logic              col_hit,
    output logic              col_owner,
    output logic [SIDX_W-1:0] col_idx
);

    logic              ent_v   [N_ENT];
    logic              ent_col [N_ENT];
    logic [AW-1:0]     ent_addr[N_ENT];
    logic              ent_own [N_ENT];
    logic [SIDX_W-1:0] ent_idx [N_ENT];

    logic tier_sel;
    assign tier_sel = wr_ok && (wr_tier == 1'(TIER));

    // Entry storage: valid bits cleared on reset, fields written on accepted writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_ENT; i++) begin
                ent_v[i]    <= 1'b0;
                ent_col[i]  <= 1'b0;
                ent_addr[i] <= '0;
                ent_own[i]  <= 1'b0;
                ent_idx[i]  <= '0;
            end
        end else if (tier_sel) begin
            ent_v[wr_slot]    <= wr_valid;
            ent_col[wr_slot]  <= wr_is_col;
            ent_addr[wr_slot] <= wr_addr;
            ent_own[wr_slot]  <= wr_owner;
            ent_idx[wr_slot]  <= wr_sidx;
        end
    end

    // Parallel compare; scanning downward lets the lowest slot win
    always_comb begin
        row_hit   = 1'b0;
        row_owner = 1'b0;
        row_idx   = '0;
        col_hit   = 1'b0;
        col_owner = 1'b0;
        col_idx   = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (ent_v[i] && !ent_col[i] && (ent_addr[i] == AW'(lk_row))) begin
                row_hit   = 1'b1;
                row_owner = ent_own[i];
                row_idx   = ent_idx[i];
            end
            if (ent_v[i] && ent_col[i] && (ent_addr[i] == AW'(lk_col))) begin
                col_hit   = 1'b1;
                col_owner = ent_own[i];
                col_idx   = ent_idx[i];
            end
        end
    end

endmodule

// File: rtl/tsr_mode_wrap.sv
// Mode wrapper: picks the array access source. In normal mode the
// functional port drives the arrays; in self-repair mode the port of the
// current master controller does. Assumes controller 0 uses the low slices.
module tsr_mode_wrap #(
    parameter int ROW_W = 6,
    parameter int COL_W = 4
) (
    input  logic               test_mode,
    input  logic               master,
    input  logic               fn_en,
    input  logic               fn_tier,
    input  logic [ROW_W-1:0]   fn_row,
    input  logic [COL_W-1:0]   fn_col,
    input  logic [1:0]         ctl_en,
    input  logic [1:0]         ctl_tier,
    input  logic [2*ROW_W-1:0] ctl_row,
    input  logic [2*COL_W-1:0] ctl_col,
    output logic               mem_en,
    output logic               mem_tier,
    output logic [ROW_W-1:0]   mem_row,
    output logic [COL_W-1:0]   mem_col
);

    // Route either the functional or the master controller's access
    always_comb begin
        if (test_mode) begin
            mem_en   = ctl_en[master];
            mem_tier = ctl_tier[master];
            mem_row  = ctl_row[master*ROW_W +: ROW_W];
            mem_col  = ctl_col[master*COL_W +: COL_W];
        end else begin
            mem_en   = fn_en;
            mem_tier = fn_tier;
            mem_row  = fn_row;
            mem_col  = fn_col;
        end
    end

endmodule

// File: rtl/tsr_role_arb.sv
// Self-repair controller role arbiter. Controller 0 is master after reset.
// The roles are exchanged when the master is faulty, the slave is healthy
// and no test is running; role_chg pulses for the cycle after the exchange.
module tsr_role_arb (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] ctl_fault,
    input  logic       test_busy,
    output logic       master,
    output logic       role_chg
);

    logic swap;
    assign swap = ctl_fault[master] && !ctl_fault[~master] && !test_busy;

    // Master register and exchange pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            master   <= 1'b0;
            role_chg <= 1'b0;
        end else begin
            master   <= master ^ swap;
            role_chg <= swap;
        end
    end

endmodule

// File: rtl/tsr_data_sel.sv
// Output data selector. The row match outranks the column match; with no
// match the main word of the accessed tier is returned. Spare words are
// packed per tier, word index = tier*N_SPR + spare index.
module tsr_data_sel #(
    parameter int DATA_W = 8,
    parameter int N_SPR  = 2,
    parameter int SIDX_W = 1
) (
    input  logic                      acc_tier,
    input  logic                      row_hit,
    input  logic                      row_owner,
    input  logic [SIDX_W-1:0]         row_idx,
    input  logic                      col_hit,
    input  logic                      col_owner,
    input  logic [SIDX_W-1:0]         col_idx,
    input  logic [2*DATA_W-1:0]       main_rd,
    input  logic [2*N_SPR*DATA_W-1:0] spr_row_rd,
    input  logic [2*N_SPR*DATA_W-1:0] spr_col_rd,
    output logic [DATA_W-1:0]         rd_data,
    output logic [1:0]                rd_src,
    output logic                      sp_tier,
    output logic [SIDX_W-1:0]         sp_idx
);
    import tsr_pkg::*;

    localparam int N_WORD = 2 * N_SPR;

    int word;

    // Choose source with row priority, then fetch the word
    always_comb begin
        word = 0;
        if (row_hit) begin
            sp_tier = row_owner;
            sp_idx  = row_idx;
            rd_src  = SRC_ROW;
        end else if (col_hit) begin
            sp_tier = col_owner;
            sp_idx  = col_idx;
            rd_src  = SRC_COL;
        end else begin
            sp_tier = 1'b0;
            sp_idx  = '0;
            rd_src  = SRC_MAIN;
        end
        word = (int'(sp_tier) * N_SPR + int'(sp_idx)) % N_WORD;
        if (rd_src == SRC_ROW)
            rd_data = spr_row_rd[word*DATA_W +: DATA_W];
        else if (rd_src == SRC_COL)
            rd_data = spr_col_rd[word*DATA_W +: DATA_W];
        else
            rd_data = main_rd[acc_tier*DATA_W +: DATA_W];
    end

endmodule

// File: rtl/dual_tier_repair.sv
// Post-bond repair datapath for two stacked memory tiers: per-tier remap
// tables with cross-tier spare ownership, output data selection, mode
// wrapper and master/slave self-repair controller arbitration.
// Assumes the arrays return main_rd and spare words for the current
// mem_* address in the same cycle.
module dual_tier_repair #(
    parameter int DATA_W = 8,
    parameter int ROW_W  = 6,
    parameter int COL_W  = 4,
    parameter int N_ENT  = 4,
    parameter int N_SPR  = 2,
    localparam int SLOT_W = $clog2(N_ENT),
    localparam int SIDX_W = $clog2(N_SPR),
    localparam int AW     = tsr_pkg::max_int(ROW_W, COL_W)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      test_mode,
    input  logic                      fn_en,
    input  logic                      fn_tier,
    input  logic [ROW_W-1:0]          fn_row,
    input  logic [COL_W-1:0]          fn_col,
    input  logic [1:0]                ctl_en,
    input  logic [1:0]                ctl_tier,
    input  logic [2*ROW_W-1:0]        ctl_row,
    input  logic [2*COL_W-1:0]        ctl_col,
    input  logic [1:0]                ctl_fault,
    input  logic                      test_busy,
    input  logic                      wr_en,
    input  logic                      wr_tier,
    input  logic [SLOT_W-1:0]         wr_slot,
    input  logic                      wr_valid,
    input  logic                      wr_is_col,
    input  logic [AW-1:0]             wr_addr,
    input  logic                      wr_owner,
    input  logic [SIDX_W-1:0]         wr_sidx,
    input  logic [2*DATA_W-1:0]       main_rd,
    input  logic [2*N_SPR*DATA_W-1:0] spr_row_rd,
    input  logic [2*N_SPR*DATA_W-1:0] spr_col_rd,
    output logic                      mem_en,
    output logic                      mem_tier,
    output logic [ROW_W-1:0]          mem_row,
    output logic [COL_W-1:0]          mem_col,
    output logic [DATA_W-1:0]         rd_data,
    output logic [1:0]                rd_src,
    output logic                      rd_spare_tier,
    output logic [SIDX_W-1:0]         rd_spare_idx,
    output logic                      master_id,
    output logic                      role_chg
);

    logic              t_row_hit [2];
    logic              t_row_own [2];
    logic [SIDX_W-1:0] t_row_idx [2];
    logic              t_col_hit [2];
    logic              t_col_own [2];
    logic [SIDX_W-1:0] t_col_idx [2];
    logic              wr_ok;

    assign wr_ok = wr_en && test_mode;

    tsr_role_arb u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_fault (ctl_fault),
        .test_busy (test_busy),
        .master    (master_id),
        .role_chg  (role_chg)
    );

    tsr_mode_wrap #(.ROW_W(ROW_W), .COL_W(COL_W)) u_wrap (
        .test_mode (test_mode),
        .master    (master_id),
        .fn_en     (fn_en),
        .fn_tier   (fn_tier),
        .fn_row    (fn_row),
        .fn_col    (fn_col),
        .ctl_en    (ctl_en),
        .ctl_tier  (ctl_tier),
        .ctl_row   (ctl_row),
        .ctl_col   (ctl_col),
        .mem_en    (mem_en),
        .mem_tier  (mem_tier),
        .mem_row   (mem_row),
        .mem_col   (mem_col)
    );

    for (genvar t = 0; t < 2; t++) begin : g_tier
        tsr_remap_table #(
            .TIER(t), .N_ENT(N_ENT), .SLOT_W(SLOT_W), .AW(AW),
            .ROW_W(ROW_W), .COL_W(COL_W), .SIDX_W(SIDX_W)
        ) u_tab (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_ok     (wr_ok),
            .wr_tier   (wr_tier),
            .wr_slot   (wr_slot),
            .wr_valid  (wr_valid),
            .wr_is_col (wr_is_col),
            .wr_addr   (wr_addr),
            .wr_owner  (wr_owner),
            .wr_sidx   (wr_sidx),
            .lk_row    (mem_row),
            .lk_col    (mem_col),
            .row_hit   (t_row_hit[t]),
            .row_owner (t_row_own[t]),
            .row_idx   (t_row_idx[t]),
            .col_hit   (t_col_hit[t]),
            .col_owner (t_col_own[t]),
            .col_idx   (t_col_idx[t])
        );
    end

    tsr_data_sel #(.DATA_W(DATA_W), .N_SPR(N_SPR), .SIDX_W(SIDX_W)) u_sel (
        .acc_tier   (mem_tier),
        .row_hit    (t_row_hit[mem_tier]),
        .row_owner  (t_row_own[mem_tier]),
        .row_idx    (t_row_idx[mem_tier]),
        .col_hit    (t_col_hit[mem_tier]),
        .col_owner  (t_col_own[mem_tier]),
        .col_idx    (t_col_idx[mem_tier]),
        .main_rd    (main_rd),
        .spr_row_rd (spr_row_rd),
        .spr_col_rd (spr_col_rd),
        .rd_data    (rd_data),
        .rd_src     (rd_src),
        .sp_tier    (rd_spare_tier),
        .sp_idx     (rd_spare_idx)
    );

endmodule

// File: rtl/dual_tier_repair_chk.sv
// Checker for dual_tier_repair: wrapper routing and role exchange rules.
module dual_tier_repair_chk #(
    parameter int ROW_W = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic               test_mode,
    input logic [ROW_W-1:0]   fn_row,
    input logic [2*ROW_W-1:0] ctl_row,
    input logic [ROW_W-1:0]   mem_row,
    input logic [1:0]         ctl_fault,
    input logic               test_busy,
    input logic               master_id,
    input logic               role_chg
);

    AST_NORMAL_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        !test_mode |-> mem_row == fn_row); // R8

    AST_REPAIR_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        test_mode |-> mem_row == ctl_row[master_id*ROW_W +: ROW_W]); // R8

    AST_PULSE_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        role_chg |-> master_id != $past(master_id)); // R9

    AST_FLIP_PULSES: assert property (@(posedge clk) disable iff (!rst_n)
        (master_id != $past(master_id)) |-> role_chg); // R9

    AST_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        role_chg |-> !$past(test_busy)); // R10

    AST_FAULT_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
        role_chg |-> $past(ctl_fault) == (master_id ? 2'b01 : 2'b10)); // R11

endmodule

bind dual_tier_repair dual_tier_repair_chk #(.ROW_W(ROW_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .test_mode (test_mode),
    .fn_row    (fn_row),
    .ctl_row   (ctl_row),
    .mem_row   (mem_row),
    .ctl_fault (ctl_fault),
    .test_busy (test_busy),
    .master_id (master_id),
    .role_chg  (role_chg)
);

// File: tb/dual_tier_repair_bench.sv
module dual_tier_repair_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DATA_W = 8, ROW_W = 6, COL_W = 4, N_ENT = 4, N_SPR = 2;
    localparam int SLOT_W = 2, SIDX_W = 1, AW = 6;

    // vector: {tier, row[5:0], col[3:0], exp data[7:0], exp src[1:0]}
    localparam int NV = 8;
    localparam logic [20:0] VEC [NV] = '{
        {1'b0, 6'd5, 4'd0, 8'h12, 2'd1},   // R4 R5 row, spare in tier 1
        {1'b0, 6'd1, 4'd3, 8'h21, 2'd2},   // R3 column, own tier
        {1'b0, 6'd5, 4'd3, 8'h12, 2'd1},   // R4 row beats column
        {1'b0, 6'd2, 4'd2, 8'hA0, 2'd0},   // R2 no match
        {1'b1, 6'd5, 4'd0, 8'hB0, 2'd0},   // R7 tier-0 entry ignored
        {1'b1, 6'd0, 4'd3, 8'h20, 2'd2},   // R3 R5 column borrowed from tier 0
        {1'b1, 6'd9, 4'd3, 8'h13, 2'd1},   // R4 row beats column in tier 1
        {1'b1, 6'd1, 4'd1, 8'hB0, 2'd0}    // R2 no match tier 1
    };

    logic clk = 1'b0;
    logic rst_n;
    logic test_mode, fn_en, fn_tier, test_busy;
    logic [ROW_W-1:0] fn_row;
    logic [COL_W-1:0] fn_col;
    logic [1:0] ctl_en, ctl_tier, ctl_fault;
    logic [2*ROW_W-1:0] ctl_row;
    logic [2*COL_W-1:0] ctl_col;
    logic wr_en, wr_tier, wr_valid, wr_is_col, wr_owner;
    logic [SLOT_W-1:0] wr_slot;
    logic [AW-1:0] wr_addr;
    logic [SIDX_W-1:0] wr_sidx;
    logic [2*DATA_W-1:0] main_rd;
    logic [2*N_SPR*DATA_W-1:0] spr_row_rd, spr_col_rd;
    logic mem_en, mem_tier, rd_spare_tier, master_id, role_chg;
    logic [ROW_W-1:0] mem_row;
    logic [COL_W-1:0] mem_col;
    logic [DATA_W-1:0] rd_data;
    logic [1:0] rd_src;
    logic [SIDX_W-1:0] rd_spare_idx;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_tier_repair u_dual_tier_repair (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic wr_entry(input logic t, input logic [1:0] s, input logic v,
                            input logic c, input logic [5:0] a, input logic o,
                            input logic i);
        @(negedge clk);
        wr_en = 1'b1; wr_tier = t; wr_slot = s; wr_valid = v;
        wr_is_col = c; wr_addr = a; wr_owner = o; wr_sidx = i;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic t, input logic [5:0] r, input logic [3:0] c);
        @(negedge clk);
        fn_en = 1'b1; fn_tier = t; fn_row = r; fn_col = c;
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; test_mode = 1'b0; fn_en = 1'b0; fn_tier = 1'b0;
        fn_row = '0; fn_col = '0; ctl_en = 2'b11; ctl_tier = 2'b00;
        ctl_row = {6'd11, 6'd7}; ctl_col = '0; ctl_fault = 2'b00; test_busy = 1'b0;
        wr_en = 1'b0; wr_tier = 1'b0; wr_slot = '0; wr_valid = 1'b0;
        wr_is_col = 1'b0; wr_addr = '0; wr_owner = 1'b0; wr_sidx = '0;
        main_rd = {8'hB0, 8'hA0};
        for (int t = 0; t < 2; t++)
            for (int i = 0; i < N_SPR; i++) begin
                spr_row_rd[(t*N_SPR+i)*DATA_W +: DATA_W] = 8'(8'h10 + t*2 + i);
                spr_col_rd[(t*N_SPR+i)*DATA_W +: DATA_W] = 8'(8'h20 + t*2 + i);
            end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(1'b0, 6'd5, 4'd3);
        chk("R1 master", master_id, 0);
        chk("R1 role_chg", role_chg, 0);
        chk("R1 data", rd_data, 8'hA0);
        chk("R1 src", rd_src, 0);

        // program tables in self-repair mode
        @(negedge clk); test_mode = 1'b1;
        wr_entry(1'b0, 2'd0, 1'b1, 1'b0, 6'd5, 1'b1, 1'b0);
        wr_entry(1'b0, 2'd1, 1'b1, 1'b1, 6'd3, 1'b0, 1'b1);
        wr_entry(1'b1, 2'd0, 1'b1, 1'b1, 6'd3, 1'b0, 1'b0);
        wr_entry(1'b1, 2'd2, 1'b1, 1'b0, 6'd9, 1'b1, 1'b1);
        @(negedge clk);
        #1 chk("R8 repair route master0", mem_row, 6'd7);
        test_mode = 1'b0;

        for (int k = 0; k < NV; k++) begin
            rd(VEC[k][20], VEC[k][19:14], VEC[k][13:10]);
            chk($sformatf("R2-5 R7 vec%0d data", k), rd_data, VEC[k][9:2]);
            chk($sformatf("R2-5 R7 vec%0d src", k), rd_src, VEC[k][1:0]);
            chk($sformatf("R8 vec%0d row", k), {mem_tier, mem_row, mem_col},
                {VEC[k][20], VEC[k][19:14], VEC[k][13:10]});
        end
        rd(1'b0, 6'd5, 4'd0);
        chk("R5 spare tier", rd_spare_tier, 1);
        chk("R5 spare idx", rd_spare_idx, 0);

        // R6 writes in normal mode are ignored
        wr_entry(1'b0, 2'd2, 1'b1, 1'b0, 6'd2, 1'b0, 1'b0);
        wr_entry(1'b0, 2'd0, 1'b0, 1'b0, 6'd5, 1'b1, 1'b0);
        rd(1'b0, 6'd2, 4'd2);
        chk("R6 ignored new entry", rd_data, 8'hA0);
        rd(1'b0, 6'd5, 4'd0);
        chk("R6 ignored invalidate", rd_data, 8'h12);

        // R2 invalidation in repair mode
        @(negedge clk); test_mode = 1'b1;
        wr_entry(1'b0, 2'd0, 1'b0, 1'b0, 6'd5, 1'b1, 1'b0);
        test_mode = 1'b0;
        rd(1'b0, 6'd5, 4'd0);
        chk("R2 invalid entry data", rd_data, 8'hA0);
        chk("R2 invalid entry src", rd_src, 0);

        // R10 held while busy
        @(negedge clk); test_busy = 1'b1; ctl_fault = 2'b01;
        repeat (3) begin
            @(negedge clk);
            chk("R10 busy master", master_id, 0);
            chk("R10 busy pulse", role_chg, 0);
        end
        test_busy = 1'b0;
        @(negedge clk);
        chk("R9 swap master", master_id, 1);
        chk("R9 swap pulse", role_chg, 1);
        ctl_fault = 2'b00;
        @(negedge clk);
        chk("R9 pulse one cycle", role_chg, 0);
        chk("R9 master held", master_id, 1);

        // R8 new master drives the arrays
        test_mode = 1'b1;
        #1 chk("R8 repair route master1", mem_row, 6'd11);

        // R11 slave-only fault and double fault
        @(negedge clk); ctl_fault = 2'b01;
        @(negedge clk);
        chk("R11 slave fault master", master_id, 1);
        chk("R11 slave fault pulse", role_chg, 0);
        ctl_fault = 2'b11;
        @(negedge clk);
        @(negedge clk);
        chk("R11 both fault master", master_id, 1);
        chk("R11 both fault pulse", role_chg, 0);
        ctl_fault = 2'b00;
        test_mode = 1'b0;

        finish_run();
    end

endmodule